// File: doc/BRIEF.md
# Symmetric Sine/Cosine Phase Mapper

This block turns a 32-bit phase word into a pair of 16-bit two's complement waveform samples, sine and cosine. The 20 most significant phase bits address one full turn: address 0 means 0 radians and each step adds 2π/2^20. The 12 least significant bits have no effect. Each angle is folded into the first quadrant. A small quarter-wave table is evaluated there. The table is computed when the design is elaborated and is refined by linear interpolation. The sign is restored from the quadrant afterwards. The cosine uses the same path, with a quarter turn added to the angle first.

Because a magnitude is never larger than 0x7FFF and is negated only as a whole, the output range is symmetric about zero. The most negative sample is 0x8001, and 0x8000 never appears in waveform mode. When the wave-enable control is low, the block forwards the raw phase bits to the outputs instead of waveform values. This allows the phase path to be observed downstream. The pipeline has two register stages, and the valid flag passes through the same two stages.

Top module: `sincos_mapper`

## Requirements
- R1: Phase bits [11:0] have no effect. Two inputs that agree in bits [31:12] give identical sine and cosine outputs.
- R2: In waveform mode, sin_o differs from round(32767·sin(2π·A/2^20)) by at most 3 LSB. A is phase bits [31:12].
- R3: In waveform mode, cos_o differs from round(32767·cos(2π·A/2^20)) by at most 3 LSB.
- R4: In waveform mode, neither output is ever 0x8000. Both outputs stay within 0x8001..0x7FFF.
- R5: The quadrant points are exact. For A = 0x00000, 0x40000, 0x80000 and 0xC0000, (sin, cos) is (0x0000, 0x7FFF), (0x7FFF, 0x0000), (0x0000, 0x8001) and (0x8001, 0x0000) in that order.
- R6: When wave_en_i is 0, sin_o equals phase bits [31:16] and cos_o equals phase bits [15:0].
- R7: vld_o equals vld_i delayed by exactly two clock cycles. Data presented with vld_i appears in the cycle in which vld_o is high.
- R8: While rst_n is low, and until new data arrives, vld_o, sin_o and cos_o are all 0.
- R9: In waveform mode, sin_o is never negative for A below 0x80000 and never positive for A at or above 0x80000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_i | input | 32 | Phase word; bits [31:12] give the angle |
| vld_i | input | 1 | Qualifies phase_i in this cycle |
| wave_en_i | input | 1 | 1: sine/cosine output; 0: raw phase forwarded |
| sin_o | output | 16 | Sine sample, or phase bits [31:16] in forward mode |
| cos_o | output | 16 | Cosine sample, or phase bits [15:0] in forward mode |
| vld_o | output | 1 | vld_i delayed by two cycles |

## Verification
The assertions require that rst_n is held low for at least two rising edges, so that both pipeline stages hold known values before any property is checked. They also require that phase_i and wave_en_i are stable around each rising edge. The bench drives every input on the falling edge and keeps reset low for several cycles, which satisfies both conditions. The sign and range properties only apply to samples taken in waveform mode. The bench mixes forward-mode samples in without disturbing them, because each property is gated by the mode bit registered in stage one.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

    localparam real PI_R = 3.14159265358979323846;

    // First-quadrant sine sample i of seg, scaled to amp and rounded.
    // Taylor series in real arithmetic, evaluated only at elaboration.
    function automatic int qsin_entry(input int i, input int seg, input int amp);
        real x;
        real term;
        real sum;
        int  k;
        int  ic;
        ic   = (i > seg) ? seg : i;
        x    = (PI_R / 2.0) * real'(ic) / real'(seg);
        term = x;
        sum  = x;
        for (k = 1; k < 10; k++) begin
            term = -term * x * x / real'((2 * k) * (2 * k + 1));
            sum  = sum + term;
        end
        sum = sum * real'(amp) + 0.5;
        if (sum > real'(amp)) sum = real'(amp);
        if (sum < 0.0) sum = 0.0;
        return $rtoi(sum);
    endfunction

endpackage

// File: rtl/sincos_fold.sv
module sincos_fold #(
    parameter int ADDR_W = 20,
    localparam int QW    = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] ang_i,
    output logic [QW:0]       pos_o,
    output logic              neg_o
);
    logic [1:0]    quad;
    logic [QW-1:0] low;

    always_comb begin
        quad = ang_i[ADDR_W-1 -: 2];
        low  = ang_i[QW-1:0];
        // odd quadrants run backwards from the quarter-turn point
        if (quad[0]) pos_o = (QW+1)'(1 << QW) - {1'b0, low};
        else         pos_o = {1'b0, low};
        // second half of the turn is negative
        neg_o = quad[1];
    end
endmodule

// File: rtl/sincos_interp.sv
module sincos_interp
    import sincos_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int OUT_W    = 16,
    parameter int TBL_BITS = 7,
    localparam int QW      = ADDR_W - 2,
    localparam int FRAC_W  = QW - TBL_BITS,
    localparam int SEG     = 1 << TBL_BITS,
    localparam int MW      = OUT_W - 1,
    localparam int AMP     = (1 << MW) - 1,
    localparam int AW      = MW + FRAC_W + 1
) (
    input  logic [QW:0]   pos_i,
    output logic [MW-1:0] mag_o
);
    logic [MW-1:0] tbl [0:SEG+1];

    for (genvar g = 0; g < SEG + 2; g++) begin : g_tbl
        assign tbl[g] = MW'(qsin_entry(g, SEG, AMP));
    end

    logic [TBL_BITS:0]   idx_d;
    logic [TBL_BITS:0]   idx1_d;
    logic [FRAC_W-1:0]   frac_d;
    logic [MW-1:0]       lo_d;
    logic [MW-1:0]       hi_d;
    logic [MW-1:0]       diff_d;
    logic [AW-1:0]       prod_d;
    logic [AW-1:0]       acc_d;
    logic [AW-FRAC_W-1:0] res_d;

    always_comb begin
        idx_d  = pos_i[QW:FRAC_W];
        idx1_d = idx_d + (TBL_BITS+1)'(1);
        frac_d = pos_i[FRAC_W-1:0];
        lo_d   = tbl[idx_d];
        hi_d   = tbl[idx1_d];
        diff_d = (hi_d >= lo_d) ? (hi_d - lo_d) : '0;
        prod_d = {{(FRAC_W+1){1'b0}}, diff_d} * {{(MW+1){1'b0}}, frac_d};
        acc_d  = {1'b0, lo_d, {FRAC_W{1'b0}}} + prod_d + AW'(1 << (FRAC_W - 1));
        res_d  = acc_d[AW-1:FRAC_W];
        mag_o  = (res_d > (AW-FRAC_W)'(AMP)) ? MW'(AMP) : res_d[MW-1:0];
    end
endmodule

// File: rtl/sincos_mapper.sv
module sincos_mapper #(
    parameter int PHASE_W  = 32,
    parameter int ADDR_W   = 20,
    parameter int OUT_W    = 16,
    parameter int TBL_BITS = 7,
    localparam int QW      = ADDR_W - 2,
    localparam int MW      = OUT_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic               vld_i,
    input  logic               wave_en_i,
    output logic [OUT_W-1:0]   sin_o,
    output logic [OUT_W-1:0]   cos_o,
    output logic               vld_o
);
    localparam logic [ADDR_W-1:0] QUARTER = ADDR_W'(1 << (ADDR_W - 2));

    typedef struct packed {
        logic               vld;
        logic               byp;
        logic [PHASE_W-1:0] raw;
        logic [QW:0]        s_pos;
        logic               s_neg;
        logic [QW:0]        c_pos;
        logic               c_neg;
    } st1_t;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] sin;
        logic [OUT_W-1:0] cos;
    } st2_t;

    st1_t st1_d, st1_q;
    st2_t st2_d, st2_q;

    logic [ADDR_W-1:0] s_ang_d;
    logic [ADDR_W-1:0] c_ang_d;
    logic [QW:0]       s_pos_w, c_pos_w;
    logic              s_neg_w, c_neg_w;
    logic [MW-1:0]     s_mag_w, c_mag_w;

    assign s_ang_d = phase_i[PHASE_W-1 -: ADDR_W];
    assign c_ang_d = s_ang_d + QUARTER;

    sincos_fold #(.ADDR_W(ADDR_W)) u_fold_sin (
        .ang_i (s_ang_d), .pos_o (s_pos_w), .neg_o (s_neg_w)
    );
    sincos_fold #(.ADDR_W(ADDR_W)) u_fold_cos (
        .ang_i (c_ang_d), .pos_o (c_pos_w), .neg_o (c_neg_w)
    );

    sincos_interp #(.ADDR_W(ADDR_W), .OUT_W(OUT_W), .TBL_BITS(TBL_BITS)) u_interp_sin (
        .pos_i (st1_q.s_pos), .mag_o (s_mag_w)
    );
    sincos_interp #(.ADDR_W(ADDR_W), .OUT_W(OUT_W), .TBL_BITS(TBL_BITS)) u_interp_cos (
        .pos_i (st1_q.c_pos), .mag_o (c_mag_w)
    );

    function automatic logic [OUT_W-1:0] apply_sign(input logic neg, input logic [MW-1:0] mag);
        logic [OUT_W-1:0] m;
        m = {1'b0, mag};
        return neg ? (~m + OUT_W'(1)) : m;
    endfunction

    always_comb begin
        // stage 1: fold both angles, keep raw word for forwarding
        st1_d.vld   = vld_i;
        st1_d.byp   = ~wave_en_i;
        st1_d.raw   = phase_i;
        st1_d.s_pos = s_pos_w;
        st1_d.s_neg = s_neg_w;
        st1_d.c_pos = c_pos_w;
        st1_d.c_neg = c_neg_w;
        // stage 2: interpolate, restore sign or forward raw bits
        st2_d.vld = st1_q.vld;
        if (st1_q.byp) begin
            st2_d.sin = st1_q.raw[PHASE_W-1 -: OUT_W];
            st2_d.cos = st1_q.raw[PHASE_W-OUT_W-1 -: OUT_W];
        end else begin
            st2_d.sin = apply_sign(st1_q.s_neg, s_mag_w);
            st2_d.cos = apply_sign(st1_q.c_neg, c_mag_w);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st1_q <= '0;
            st2_q <= '0;
        end else begin
            st1_q <= st1_d;
            st2_q <= st2_d;
        end
    end

    assign sin_o = st2_q.sin;
    assign cos_o = st2_q.cos;
    assign vld_o = st2_q.vld;

    AST_VLD_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o == $past(st1_q.vld)); // R7
    AST_NO_NEG_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!st1_q.byp) |-> (sin_o != {1'b1, {MW{1'b0}}}) && (cos_o != {1'b1, {MW{1'b0}}})); // R4
    AST_BYPASS_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        st1_q.byp |=> sin_o == $past(st1_q.raw[PHASE_W-1 -: OUT_W])); // R6
    AST_SIN_SIGN_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (!st1_q.byp && !st1_q.s_neg) |=> !sin_o[OUT_W-1]); // R9
    AST_SIN_SIGN_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (!st1_q.byp && st1_q.s_neg) |=> (sin_o[OUT_W-1] || sin_o == '0)); // R9
endmodule

// File: tb/tb_sincos_mapper.sv
module tb_sincos_mapper;
    localparam time CLK_PERIOD = 10ns;
    localparam real PI_R = 3.14159265358979323846;
    localparam int  TOL  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] phase_i = '0;
    logic        vld_i = 1'b0;
    logic        wave_en_i = 1'b1;
    logic [15:0] sin_o, cos_o;
    logic        vld_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sincos_mapper dut (
        .clk(clk), .rst_n(rst_n), .phase_i(phase_i), .vld_i(vld_i),
        .wave_en_i(wave_en_i), .sin_o(sin_o), .cos_o(cos_o), .vld_o(vld_o)
    );

    function automatic int ref_val(input logic [19:0] a, input bit is_cos);
        real r;
        real ang;
        ang = 2.0 * PI_R * real'(a) / 1048576.0;
        r = 32767.0 * (is_cos ? $cos(ang) : $sin(ang));
        return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive one sample at a falling edge, sample result two edges later
    task automatic run(input logic [31:0] ph, input bit wen,
                       output logic [15:0] s, output logic [15:0] c, output logic v);
        phase_i   = ph;
        wave_en_i = wen;
        vld_i     = 1'b1;
        @(negedge clk);
        vld_i = 1'b0;
        @(negedge clk);
        s = sin_o;
        c = cos_o;
        v = vld_o;
    endtask

    task automatic t_reset;
        chk(vld_o == 1'b0, "R8 vld_o in reset", int'(vld_o), 0);
        chk(sin_o == 16'h0, "R8 sin_o in reset", int'(sin_o), 0);
        chk(cos_o == 16'h0, "R8 cos_o in reset", int'(cos_o), 0);
    endtask

    task automatic t_quadrants;
        logic [15:0] s, c;
        logic v;
        logic [15:0] es [4] = '{16'h0000, 16'h7FFF, 16'h0000, 16'h8001};
        logic [15:0] ec [4] = '{16'h7FFF, 16'h0000, 16'h8001, 16'h0000};
        for (int q = 0; q < 4; q++) begin
            run(32'(q) << 30, 1'b1, s, c, v);
            chk(s == es[q], "R5 sin at quadrant point", int'(s), int'(es[q]));
            chk(c == ec[q], "R5 cos at quadrant point", int'(c), int'(ec[q]));
        end
    endtask

    task automatic t_sweep;
        logic [15:0] s, c;
        logic v;
        logic [31:0] ph;
        int bad_s, bad_c, bad_r, bad_g;
        int ws, wc;
        bad_s = 0; bad_c = 0; bad_r = 0; bad_g = 0; ws = 0; wc = 0;
        ph = 32'h0001_3579;
        for (int i = 0; i < 600; i++) begin
            int es, ec, ds, dc;
            run(ph, 1'b1, s, c, v);
            es = ref_val(ph[31:12], 1'b0);
            ec = ref_val(ph[31:12], 1'b1);
            ds = int'($signed(s)) - es;
            dc = int'($signed(c)) - ec;
            if (ds > TOL || ds < -TOL) begin bad_s++; ws = ds; end
            if (dc > TOL || dc < -TOL) begin bad_c++; wc = dc; end
            if (s == 16'h8000 || c == 16'h8000) bad_r++;
            if (ph[31] == 1'b0 && s[15]) bad_g++;
            if (ph[31] == 1'b1 && !s[15] && s != 16'h0) bad_g++;
            ph = ph + 32'h006D_3A17 + 32'(i * 4099);
        end
        chk(bad_s == 0, "R2 sine error over sweep (count, worst diff)", bad_s, ws);
        chk(bad_c == 0, "R3 cosine error over sweep (count, worst diff)", bad_c, wc);
        chk(bad_r == 0, "R4 0x8000 seen in sweep", bad_r, 0);
        chk(bad_g == 0, "R9 sine sign wrong in sweep", bad_g, 0);
    endtask

    task automatic t_neg_edge;
        logic [15:0] s, c;
        logic v;
        // angles next to the negative peaks
        run(32'hBFFF_F000, 1'b1, s, c, v);
        chk(s != 16'h8000 && $signed(s) <= -16'sd32760, "R4 sine near negative peak", int'($signed(s)), -32767);
        run(32'h8000_1000, 1'b1, s, c, v);
        chk(c != 16'h8000 && $signed(c) <= -16'sd32760, "R4 cosine near negative peak", int'($signed(c)), -32767);
    endtask

    task automatic t_lowbits;
        logic [15:0] s0, c0, s1, c1;
        logic v;
        run(32'h2345_6000, 1'b1, s0, c0, v);
        run(32'h2345_6FFF, 1'b1, s1, c1, v);
        chk(s0 == s1, "R1 sine depends on low bits", int'(s1), int'(s0));
        chk(c0 == c1, "R1 cosine depends on low bits", int'(c1), int'(c0));
        run(32'hD00D_0ABC, 1'b1, s1, c1, v);
        run(32'hD00D_0000, 1'b1, s0, c0, v);
        chk(s0 == s1 && c0 == c1, "R1 outputs depend on low bits", int'(s1), int'(s0));
    endtask

    task automatic t_bypass;
        logic [15:0] s, c;
        logic v;
        run(32'hA5C3_1E7F, 1'b0, s, c, v);
        chk(s == 16'hA5C3, "R6 forwarded upper half", int'(s), 32'hA5C3);
        chk(c == 16'h1E7F, "R6 forwarded lower half", int'(c), 32'h1E7F);
        run(32'h8000_0000, 1'b0, s, c, v);
        chk(s == 16'h8000 && c == 16'h0000, "R6 forwarding passes 0x8000", int'(s), 32'h8000);
        run(32'h4000_0000, 1'b1, s, c, v);
        chk(s == 16'h7FFF, "R6 waveform mode restored", int'(s), 32'h7FFF);
    endtask

    task automatic t_latency;
        logic v1, v2, v3;
        logic [15:0] s2;
        phase_i   = 32'h4000_0000;
        wave_en_i = 1'b1;
        vld_i     = 1'b1;
        @(negedge clk);
        vld_i   = 1'b0;
        phase_i = 32'h0;
        v1 = vld_o;
        @(negedge clk);
        v2 = vld_o;
        s2 = sin_o;
        @(negedge clk);
        v3 = vld_o;
        chk(v1 == 1'b0, "R7 vld_o one cycle after input", int'(v1), 0);
        chk(v2 == 1'b1, "R7 vld_o two cycles after input", int'(v2), 1);
        chk(s2 == 16'h7FFF, "R7 data aligned with vld_o", int'(s2), 32'h7FFF);
        chk(v3 == 1'b0, "R7 vld_o single cycle", int'(v3), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_quadrants();
        t_latency();
        t_lowbits();
        t_bypass();
        t_neg_edge();
        t_sweep();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R7 actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule